// File: doc/BRIEF.md
# Transmit Start Gating Controller

This block tells a network MAC the moment it may begin sending the preamble of the frame at the head of its transmit queue. It watches two things: how many bytes of the current frame already sit in the MAC transmit FIFO, and whether the DMA engine has reported that the whole frame has been fetched into local storage. A two-bit start-point code selects the byte threshold. A separate underflow-guard enable adds a second rule: the whole frame must have been fetched before the preamble may start.

The configuration port writes the start-point code and the guard enable together. The code is accepted at any time. The guard enable is accepted only while the controller is stopped or suspended. The guard is cleared by both hard and soft reset, and it never acts while the system runs without external buffer memory. The result is a one-cycle start strobe. The strobe fires once per frame and is rearmed by an end-of-frame pulse from the serializer.

Top module: `tx_start_gate`

## Requirements
- R1: After hard reset `tx_start` is 0, `start_code_rd` reads 0 and `guard_en_rd` reads 0.
- R2: With the effective guard off and start-point code 0, 1 or 2, `tx_start` rises in the cycle after `fifo_level` is greater than or equal to 64, 128 or 256 bytes respectively. Lower levels never start the frame.
- R3: With the effective guard off and code 3 (whole frame), the strobe waits for the frame-fetched flag, whatever the FIFO level.
- R4: With the effective guard on and code 0, 1 or 2, the strobe needs both the byte threshold and the frame-fetched flag.
- R5: With the effective guard on and code 3, the frame-fetched flag alone is enough; the code adds no byte threshold.
- R6: `tx_start` is a single-cycle pulse, issued at most once per frame. After it fires, no further strobe comes until a `frame_end` pulse rearms the block.
- R7: A `fetch_done` pulse sets the frame-fetched flag. The flag is cleared by the edge that raises `tx_start`, and a clear has priority over a set in the same cycle.
- R8: A configuration write changes `guard_en_rd` only while `stopped` or `suspended` is 1. At other times the guard value in the write is ignored.
- R9: `soft_rst` clears the guard enable, the frame-fetched flag and any pending strobe, and rearms the block. `stopped` by itself never changes the guard enable.
- R10: While `no_ext_mem` is 1 the stored guard enable has no effect, and start follows the guard-off rules of R2 and R3.
- R11: The start-point code in a write is taken in every state and reads back on `start_code_rd` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| stopped | input | 1 | Controller stopped status |
| suspended | input | 1 | Controller suspended status |
| no_ext_mem | input | 1 | System runs without external buffer memory |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_start_code | input | 2 | Start-point code to write (0: 64 B, 1: 128 B, 2: 256 B, 3: whole frame) |
| cfg_guard_en | input | 1 | Underflow-guard enable to write |
| fifo_level | input | OCC_W | Bytes of the current frame in the MAC transmit FIFO |
| fetch_done | input | 1 | Pulse: the DMA has fetched the whole frame |
| frame_end | input | 1 | Pulse: the current frame is finished; rearms the strobe |
| tx_start | output | 1 | One-cycle pulse: begin the preamble |
| start_code_rd | output | 2 | Stored start-point code |
| guard_en_rd | output | 1 | Stored underflow-guard enable |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. A level or fetched flag present before edge k yields `tx_start` after edge k. A `fetch_done` pulse before edge k sets the flag at edge k, so the strobe comes after edge k+1. A write shows on the readback ports after the edge that takes it. The bench drives inputs only just after a rising edge. It advances its reference model on the same edge from the inputs that edge saw, and compares all three outputs 1 ns later, so every comparison falls in the cycle in which the result is due.

// File: rtl/txg_pkg.sv
package txg_pkg;
   typedef logic [1:0] sp_code_t;

   localparam sp_code_t SP_WHOLE = 2'd3;
   localparam int unsigned SP_LEVELS = 3;

   function automatic int unsigned sp_bytes(input int unsigned base, input int unsigned code);
      return base << code;
   endfunction
endpackage

// File: rtl/txg_cfg.sv
module txg_cfg
   import txg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     soft_rst,
   input  logic     stopped,
   input  logic     suspended,
   input  logic     no_ext_mem,
   input  logic     wr,
   input  sp_code_t wr_code,
   input  logic     wr_guard,
   output sp_code_t code_q,
   output logic     guard_q,
   output logic     guard_eff
);
   logic guard_open;
   assign guard_open = stopped | suspended;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (wr) begin
         code_q <= wr_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         guard_q <= 1'b0;
      end else if (soft_rst) begin
         guard_q <= 1'b0;
      end else if (wr && guard_open) begin
         guard_q <= wr_guard;
      end
   end

   assign guard_eff = guard_q & ~no_ext_mem;

   AST_GUARD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && !(wr && guard_open)) |=> $stable(guard_q)); // R8
   AST_SOFT_CLEARS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !guard_q); // R9
endmodule

// File: rtl/txg_thresh.sv
module txg_thresh
   import txg_pkg::*;
#(
   parameter int unsigned OCC_W      = 12,
   parameter int unsigned BASE_BYTES = 64
) (
   input  logic [OCC_W-1:0] level,
   input  sp_code_t         code,
   input  logic             fetched,
   input  logic             guard_eff,
   output logic             ready
);
   localparam int unsigned MAX_BYTES = sp_bytes(BASE_BYTES, SP_LEVELS - 1);
   localparam int unsigned NEED_W    = $clog2(MAX_BYTES + 1);

   if (OCC_W < NEED_W) begin : g_bad_width
      $error("txg_thresh: OCC_W too narrow for the largest start point");
   end
   if (BASE_BYTES == 0) begin : g_bad_base
      $error("txg_thresh: BASE_BYTES must be non-zero");
   end

   logic [SP_LEVELS-1:0] hit;

   for (genvar i = 0; i < SP_LEVELS; i++) begin : g_level
      localparam logic [OCC_W-1:0] LIMIT = OCC_W'(sp_bytes(BASE_BYTES, i));
      assign hit[i] = (level >= LIMIT);
   end

   always_comb begin
      if (code == SP_WHOLE) begin
         ready = guard_eff | fetched;
      end else begin
         ready = hit[code];
      end
   end
endmodule

// File: rtl/txg_gate.sv
module txg_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic ready,
   input  logic guard_eff,
   input  logic fetch_done,
   input  logic frame_end,
   output logic tx_start,
   output logic fetched_q
);
   logic armed_q;
   logic cond;
   logic fire;

   assign cond = ready & (~guard_eff | fetched_q);
   assign fire = armed_q & cond & ~tx_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_start  <= 1'b0;
         armed_q   <= 1'b1;
         fetched_q <= 1'b0;
      end else if (soft_rst) begin
         tx_start  <= 1'b0;
         armed_q   <= 1'b1;
         fetched_q <= 1'b0;
      end else begin
         tx_start <= fire;
         if (frame_end) begin
            armed_q <= 1'b1;
         end else if (fire) begin
            armed_q <= 1'b0;
         end
         if (fire) begin
            fetched_q <= 1'b0;
         end else if (fetch_done) begin
            fetched_q <= 1'b1;
         end
      end
   end

   AST_ONE_CYCLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start); // R6
   AST_GUARD_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_eff && !fetched_q) |=> !tx_start); // R4
   AST_FETCH_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> !fetched_q); // R7
endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
   import txg_pkg::*;
#(
   parameter int unsigned OCC_W      = 12,
   parameter int unsigned BASE_BYTES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             stopped,
   input  logic             suspended,
   input  logic             no_ext_mem,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_start_code,
   input  logic             cfg_guard_en,
   input  logic [OCC_W-1:0] fifo_level,
   input  logic             fetch_done,
   input  logic             frame_end,
   output logic             tx_start,
   output logic [1:0]       start_code_rd,
   output logic             guard_en_rd
);
   sp_code_t code_q;
   logic     guard_q;
   logic     guard_eff;
   logic     ready;
   logic     fetched_q;

   txg_cfg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .stopped   (stopped),
      .suspended (suspended),
      .no_ext_mem(no_ext_mem),
      .wr        (cfg_wr),
      .wr_code   (cfg_start_code),
      .wr_guard  (cfg_guard_en),
      .code_q    (code_q),
      .guard_q   (guard_q),
      .guard_eff (guard_eff)
   );

   txg_thresh #(
      .OCC_W     (OCC_W),
      .BASE_BYTES(BASE_BYTES)
   ) u_thresh (
      .level    (fifo_level),
      .code     (code_q),
      .fetched  (fetched_q),
      .guard_eff(guard_eff),
      .ready    (ready)
   );

   txg_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .ready     (ready),
      .guard_eff (guard_eff),
      .fetch_done(fetch_done),
      .frame_end (frame_end),
      .tx_start  (tx_start),
      .fetched_q (fetched_q)
   );

   assign start_code_rd = code_q;
   assign guard_en_rd   = guard_q;

   AST_CODE3_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q == SP_WHOLE && !fetched_q && !soft_rst) |=> !tx_start); // R3
endmodule

// File: tb/tx_start_gate_test.sv
module tx_start_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int OCC_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             soft_rst = 1'b0;
   logic             stopped = 1'b0;
   logic             suspended = 1'b0;
   logic             no_ext_mem = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [1:0]       cfg_start_code = 2'd0;
   logic             cfg_guard_en = 1'b0;
   logic [OCC_W-1:0] fifo_level = '0;
   logic             fetch_done = 1'b0;
   logic             frame_end = 1'b0;
   logic             tx_start;
   logic [1:0]       start_code_rd;
   logic             guard_en_rd;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // reference model state
   int m_start = 0, m_armed = 1, m_fetched = 0, m_code = 0, m_guard = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tx_start_gate #(.OCC_W(OCC_W), .BASE_BYTES(64)) uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stopped(stopped),
      .suspended(suspended), .no_ext_mem(no_ext_mem), .cfg_wr(cfg_wr),
      .cfg_start_code(cfg_start_code), .cfg_guard_en(cfg_guard_en),
      .fifo_level(fifo_level), .fetch_done(fetch_done), .frame_end(frame_end),
      .tx_start(tx_start), .start_code_rd(start_code_rd), .guard_en_rd(guard_en_rd)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(cur_req, "tx_start", 32'(tx_start), m_start);
      chk(cur_req, "start_code_rd", 32'(start_code_rd), m_code);
      chk(cur_req, "guard_en_rd", 32'(guard_en_rd), m_guard);
   endtask

   // one clock: model consumes the inputs seen by the edge, outputs compared 1 ns later
   task automatic step();
      int g_eff, thr, cond, fire;
      int n_start, n_armed, n_fetched, n_code, n_guard;
      g_eff = (m_guard != 0 && !no_ext_mem) ? 1 : 0;
      if (m_code == 3) thr = (g_eff != 0 || m_fetched != 0) ? 1 : 0;
      else thr = (int'(fifo_level) >= (64 * (2 ** m_code))) ? 1 : 0;
      cond = (thr != 0 && (g_eff == 0 || m_fetched != 0)) ? 1 : 0;
      fire = (m_armed != 0 && cond != 0 && m_start == 0) ? 1 : 0;
      n_code = cfg_wr ? int'(cfg_start_code) : m_code;
      n_guard = m_guard;
      if (soft_rst) begin
         n_start = 0; n_armed = 1; n_fetched = 0; n_guard = 0;
      end else begin
         n_start = fire;
         n_armed = frame_end ? 1 : (fire != 0 ? 0 : m_armed);
         n_fetched = fire != 0 ? 0 : (fetch_done ? 1 : m_fetched);
         if (cfg_wr && (stopped || suspended)) n_guard = int'(cfg_guard_en);
      end
      @(posedge clk);
      m_start = n_start; m_armed = n_armed; m_fetched = n_fetched;
      m_code = n_code; m_guard = n_guard;
      #1;
      compare_all();
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic write_cfg(input int code, input logic g);
      cfg_wr = 1'b1; cfg_start_code = 2'(code); cfg_guard_en = g;
      step();
      cfg_wr = 1'b0;
   endtask

   task automatic pulse_fetch();
      fetch_done = 1'b1; step(); fetch_done = 1'b0;
   endtask

   task automatic pulse_end();
      frame_end = 1'b1; step(); frame_end = 1'b0;
   endtask

   // clear level and rearm between scenarios
   task automatic idle_rearm();
      fifo_level = '0;
      step();
      pulse_end();
      step();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: reset state
      cur_req = "R1";
      compare_all();
      steps(2);

      // R2: code 0, threshold 64 with >=
      cur_req = "R2";
      fifo_level = 12'd63; steps(3);
      fifo_level = 12'd64; step();
      chk("R2", "start at 64", 32'(tx_start), 1);
      // R6: single pulse, no second strobe without frame_end
      cur_req = "R6";
      steps(4);
      chk("R6", "no restart", 32'(tx_start), 0);
      pulse_end(); step();
      chk("R6", "rearm restart", 32'(tx_start), 1);
      idle_rearm();

      // R11 + R2: codes 1 and 2 accepted while running
      cur_req = "R11";
      write_cfg(1, 1'b0);
      chk("R11", "code 1 readback", 32'(start_code_rd), 1);
      cur_req = "R2";
      fifo_level = 12'd127; steps(3);
      fifo_level = 12'd128; steps(2);
      idle_rearm();
      write_cfg(2, 1'b0);
      fifo_level = 12'd255; steps(3);
      fifo_level = 12'd256; steps(2);
      idle_rearm();

      // R3: code 3 without guard waits for the fetched flag
      cur_req = "R3";
      write_cfg(3, 1'b0);
      fifo_level = 12'd2000; steps(4);
      chk("R3", "no start before fetch", 32'(tx_start), 0);
      // R7: flag latched from the pulse, strobe one cycle later
      cur_req = "R7";
      pulse_fetch(); steps(3);
      idle_rearm();

      // R8: guard write ignored while running
      cur_req = "R8";
      write_cfg(0, 1'b1);
      chk("R8", "guard ignored", 32'(guard_en_rd), 0);
      stopped = 1'b1;
      write_cfg(0, 1'b1);
      chk("R8", "guard taken when stopped", 32'(guard_en_rd), 1);
      stopped = 1'b0; step();
      // R9: releasing stop leaves guard as it is
      chk("R9", "stop change keeps guard", 32'(guard_en_rd), 1);

      // R4: guard on, threshold met but fetch missing
      cur_req = "R4";
      fifo_level = 12'd100; steps(4);
      chk("R4", "no start without fetch", 32'(tx_start), 0);
      pulse_fetch(); steps(3);
      idle_rearm();
      // R4: fetch first, level later
      fifo_level = 12'd10;
      pulse_fetch(); steps(3);
      fifo_level = 12'd64; steps(3);
      idle_rearm();

      // R5: code 3 with guard, fetch alone suffices at level 0
      cur_req = "R5";
      write_cfg(3, 1'b0);
      chk("R5", "guard kept after ignored write", 32'(guard_en_rd), 1);
      pulse_fetch(); steps(3);
      idle_rearm();

      // R10: no external memory disables the guard
      cur_req = "R10";
      write_cfg(0, 1'b0);
      no_ext_mem = 1'b1;
      fifo_level = 12'd64; steps(3);
      idle_rearm();
      no_ext_mem = 1'b0;

      // R7: fetch pulse in the firing cycle is dropped (clear wins)
      cur_req = "R7";
      fifo_level = 12'd64;
      pulse_fetch(); // fetched set, level met
      fetch_done = 1'b1; step(); fetch_done = 1'b0; // fire edge with fetch pulse
      steps(3);
      idle_rearm();

      // R9: soft reset clears guard and pending fetch
      cur_req = "R9";
      suspended = 1'b1;
      write_cfg(0, 1'b1);
      suspended = 1'b0;
      pulse_fetch();
      soft_rst = 1'b1; step(); soft_rst = 1'b0;
      chk("R9", "soft reset clears guard", 32'(guard_en_rd), 0);
      fifo_level = 12'd70; steps(3);
      idle_rearm();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (scenario %s) actual=running expected=finished", cur_req);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule